// File: doc/BRIEF.md
# I2C Byte Transmitter

This block is a single-controller engine for a two-wire serial bus. A local agent hands it one command at a time: open a transfer (START), send one byte (WRITE), or close the transfer (STOP). The engine shapes the clock and data lines through two open-drain pull enables. A high level appears on a line only when the block lets go of it and the external pull-up raises it; the block never drives a line high. A per-bit timing unit counts quarter periods of the bus clock, and its length comes from a divider input.

START and STOP are built from single line moves in a fixed order, one line at a time. A WRITE shifts the byte out most significant bit first and then lets go of the data line for a ninth clock. During that ninth clock it samples whether the addressed target pulls the data line low. Each command ends with a done pulse one cycle wide, and a NACK flag is reported with it. After a START or a WRITE the block keeps the clock line pulled low for as long as the local agent takes to issue the next command. The bus has no minimum clock rate, so this pause is harmless.

When the block releases the clock line it reads the line back. A target that keeps the line low delays the high phase until the line actually reads high.

Top module: `i2c_byte_tx`

## Requirements
- R1: After reset both pull enables are 0 (both lines float high), and busy, done and nack are 0.
- R2: START (cmd_op 2'b01) first releases SDA, then releases SCL, then pulls SDA low while SCL is high, and finally pulls SCL low. The two pull enables never change in the same cycle. START is also legal while the bus is held, which gives a repeated start.
- R3: WRITE (cmd_op 2'b10) sends cmd_data as 8 bits, most significant first. SDA is pulled for a 0 and released for a 1. SDA changes only while SCL is pulled low, so a write makes no start or stop event.
- R4: After the eighth bit, SDA is released for a ninth SCL pulse and sampled while SCL is high. nack becomes 0 if the target pulls SDA low and 1 if SDA reads high. nack rises only together with done and stays valid until the next accepted command.
- R5: STOP (cmd_op 2'b11) pulls SDA low with SCL low, then releases SCL, then releases SDA while SCL is high. Afterwards both lines are released.
- R6: One quarter period lasts clk_div+1 clock cycles. Each SCL high phase of a bit and each SCL low phase between two bits of a byte last 2*(clk_div+1) cycles.
- R7: While SCL is released but reads low, the quarter counter is paused. The high phase is counted from the cycle in which SCL reads high.
- R8: A command is taken only when cmd_valid is 1 and busy is 0. busy covers the whole command and its done cycle. Each command yields exactly one done pulse of one cycle. A command presented while busy is ignored.
- R9: Between commands the pull enables do not move. After START or WRITE, SCL stays pulled low for any length of pause.
- R10: WRITE or STOP issued while the bus is not held completes with done and nack=1 and does not touch the lines. cmd_op 2'b00 completes with done and nack=0 and no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 00 none, 01 START, 10 WRITE, 11 STOP |
| cmd_data | input | DATA_W | Byte sent by WRITE |
| clk_div | input | DIV_W | Quarter period length minus one, in clock cycles |
| busy | output | 1 | Command in progress or finishing; new commands refused |
| done | output | 1 | One-cycle end-of-command pulse |
| nack | output | 1 | Target did not acknowledge, or command rejected |
| scl_in | input | 1 | SCL level read back from the bus |
| sda_in | input | 1 | SDA level read back from the bus |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The write path is tried with four bytes. 0xA5 and 0x3C alternate bit values in different places, so a bit-order swap or an inverted pull shows up. 0x81 has lone ones at both ends and is run with the shortest divider, which exposes off-by-one errors in phase length. 0x5A is run while a target stretches the clock, which separates a counter that honours the readback from one that counts through the stretch. Acknowledged and unacknowledged bytes show whether the ninth-clock sample is taken. START, repeated START, STOP and rejected commands are told apart by the count of start and stop events that a bus monitor decodes from the line levels.

// File: rtl/i2c_tx_pkg.sv
package i2c_tx_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_START = 2'b01,
      OP_WRITE = 2'b10,
      OP_STOP  = 2'b11
   } i2c_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_START,
      ST_WRITE,
      ST_STOP
   } i2c_state_e;

   // pull enables for the two bus lines: 1 = pull low, 0 = release
   typedef struct packed {
      logic scl_pull;
      logic sda_pull;
   } i2c_lines_t;

   localparam logic [1:0] QTR_LAST_START = 2'd3;
   localparam logic [1:0] QTR_LAST_STOP  = 2'd2;
   localparam logic [1:0] QTR_LAST_BIT   = 2'd3;
   localparam logic [1:0] QTR_SAMPLE     = 2'd1;

endpackage

// File: rtl/i2c_tx_qtimer.sv
module i2c_tx_qtimer #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hold,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("i2c_tx_qtimer: DIV_W must be at least 1");
      end
   endgenerate

   // a quarter ends after div+1 counted cycles; >= guards a divider lowered mid-count
   assign tick = run && !hold && (cnt_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (!hold) begin
         cnt_q <= tick ? '0 : cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/i2c_tx_shreg.sv
module i2c_tx_shreg #(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic [DATA_W-1:0] din,
   output logic              bit_next
);

   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] sh_shifted;
   logic              cur_bit;
   logic              nxt_bit;
   logic              first_bit;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("i2c_tx_shreg: DATA_W must be at least 2");
      end
      if (MSB_FIRST) begin : g_msb
         assign cur_bit    = sh_q[DATA_W-1];
         assign nxt_bit    = sh_q[DATA_W-2];
         assign first_bit  = din[DATA_W-1];
         assign sh_shifted = {sh_q[DATA_W-2:0], 1'b0};
      end else begin : g_lsb
         assign cur_bit    = sh_q[0];
         assign nxt_bit    = sh_q[1];
         assign first_bit  = din[0];
         assign sh_shifted = {1'b0, sh_q[DATA_W-1:1]};
      end
   endgenerate

   // bit presented on the line once this cycle's load/shift has taken effect
   assign bit_next = load ? first_bit : (shift ? nxt_bit : cur_bit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load) begin
         sh_q <= din;
      end else if (shift) begin
         sh_q <= sh_shifted;
      end
   end

endmodule

// File: rtl/i2c_tx_seq.sv
module i2c_tx_seq
   import i2c_tx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [1:0] cmd_op,
   input  logic       tick,
   input  logic       data_bit,
   input  logic       sda_in,
   output logic       busy,
   output logic       done,
   output logic       nack,
   output logic       timer_run,
   output logic       load,
   output logic       shift,
   output i2c_lines_t lines
);

   localparam int BCNT_W = $clog2(DATA_W + 1);
   localparam logic [BCNT_W-1:0] ACK_IDX = BCNT_W'(DATA_W);

   i2c_state_e        st_q, st_n;
   logic [1:0]        qtr_q, qtr_n;
   logic [BCNT_W-1:0] bit_q, bit_n;
   logic              own_q, own_n;
   logic              ack_q, ack_n;
   logic              nack_q, nack_n;
   logic              done_q, done_n;
   i2c_lines_t        lines_q, lines_n;
   logic              accept;

   assign accept    = cmd_valid && (st_q == ST_IDLE) && !done_q;
   assign busy      = (st_q != ST_IDLE) || done_q;
   assign done      = done_q;
   assign nack      = nack_q;
   assign lines     = lines_q;
   assign timer_run = (st_q != ST_IDLE);

   // command sequencing, one quarter per timer tick
   always_comb begin
      st_n   = st_q;
      qtr_n  = qtr_q;
      bit_n  = bit_q;
      own_n  = own_q;
      ack_n  = ack_q;
      nack_n = nack_q;
      done_n = 1'b0;
      load   = 1'b0;
      shift  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (accept) begin
               nack_n = 1'b0;
               qtr_n  = 2'd0;
               bit_n  = '0;
               unique case (i2c_op_e'(cmd_op))
                  OP_START: st_n = ST_START;
                  OP_WRITE: begin
                     if (own_q) begin
                        st_n = ST_WRITE;
                        load = 1'b1;
                     end else begin
                        done_n = 1'b1;
                        nack_n = 1'b1;
                     end
                  end
                  OP_STOP: begin
                     if (own_q) begin
                        st_n = ST_STOP;
                     end else begin
                        done_n = 1'b1;
                        nack_n = 1'b1;
                     end
                  end
                  default: done_n = 1'b1;
               endcase
            end
         end
         ST_START: begin
            if (tick) begin
               if (qtr_q == QTR_LAST_START) begin
                  st_n   = ST_IDLE;
                  own_n  = 1'b1;
                  done_n = 1'b1;
               end else begin
                  qtr_n = qtr_q + 2'd1;
               end
            end
         end
         ST_STOP: begin
            if (tick) begin
               if (qtr_q == QTR_LAST_STOP) begin
                  st_n   = ST_IDLE;
                  own_n  = 1'b0;
                  done_n = 1'b1;
               end else begin
                  qtr_n = qtr_q + 2'd1;
               end
            end
         end
         ST_WRITE: begin
            if (tick) begin
               if ((qtr_q == QTR_SAMPLE) && (bit_q == ACK_IDX)) begin
                  ack_n = sda_in;
               end
               if (qtr_q == QTR_LAST_BIT) begin
                  if (bit_q == ACK_IDX) begin
                     st_n   = ST_IDLE;
                     done_n = 1'b1;
                     nack_n = ack_q;
                  end else begin
                     bit_n = bit_q + 1'b1;
                     qtr_n = 2'd0;
                     shift = (bit_q != ACK_IDX - 1'b1);
                  end
               end else begin
                  qtr_n = qtr_q + 2'd1;
               end
            end
         end
         default: st_n = ST_IDLE;
      endcase
   end

   // line levels for the quarter entered next
   always_comb begin
      lines_n = lines_q;
      unique case (st_n)
         ST_START: begin
            unique case (qtr_n)
               2'd0:    lines_n = '{scl_pull: own_q, sda_pull: 1'b0};
               2'd1:    lines_n = '{scl_pull: 1'b0,  sda_pull: 1'b0};
               2'd2:    lines_n = '{scl_pull: 1'b0,  sda_pull: 1'b1};
               default: lines_n = '{scl_pull: 1'b1,  sda_pull: 1'b1};
            endcase
         end
         ST_STOP: begin
            unique case (qtr_n)
               2'd0:    lines_n = '{scl_pull: 1'b1, sda_pull: 1'b1};
               2'd1:    lines_n = '{scl_pull: 1'b0, sda_pull: 1'b1};
               default: lines_n = '{scl_pull: 1'b0, sda_pull: 1'b0};
            endcase
         end
         ST_WRITE: begin
            lines_n.scl_pull = !((qtr_n == 2'd1) || (qtr_n == 2'd2));
            lines_n.sda_pull = (bit_n == ACK_IDX) ? 1'b0 : !data_bit;
         end
         default: lines_n = lines_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         qtr_q   <= 2'd0;
         bit_q   <= '0;
         own_q   <= 1'b0;
         ack_q   <= 1'b0;
         nack_q  <= 1'b0;
         done_q  <= 1'b0;
         lines_q <= '{scl_pull: 1'b0, sda_pull: 1'b0};
      end else begin
         st_q    <= st_n;
         qtr_q   <= qtr_n;
         bit_q   <= bit_n;
         own_q   <= own_n;
         ack_q   <= ack_n;
         nack_q  <= nack_n;
         done_q  <= done_n;
         lines_q <= lines_n;
      end
   end

endmodule

// File: rtl/i2c_byte_tx.sv
module i2c_byte_tx
   import i2c_tx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int DIV_W     = 12,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic [DIV_W-1:0]  clk_div,
   output logic              busy,
   output logic              done,
   output logic              nack,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe
);

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("i2c_byte_tx: DATA_W must be at least 2");
      end
      if (DIV_W < 1 || DIV_W > 31) begin : g_bad_div_w
         $error("i2c_byte_tx: DIV_W must be between 1 and 31");
      end
   endgenerate

   logic       tick;
   logic       timer_run;
   logic       timer_hold;
   logic       sh_load;
   logic       sh_shift;
   logic       data_bit;
   i2c_lines_t lines;

   // a released clock line that still reads low is held by a target
   assign timer_hold = !lines.scl_pull && !scl_in;

   i2c_tx_qtimer #(.DIV_W(DIV_W)) u_qtimer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (timer_run),
      .hold  (timer_hold),
      .div   (clk_div),
      .tick  (tick)
   );

   i2c_tx_shreg #(.DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_shreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .shift    (sh_shift),
      .din      (cmd_data),
      .bit_next (data_bit)
   );

   i2c_tx_seq #(.DATA_W(DATA_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .tick      (tick),
      .data_bit  (data_bit),
      .sda_in    (sda_in),
      .busy      (busy),
      .done      (done),
      .nack      (nack),
      .timer_run (timer_run),
      .load      (sh_load),
      .shift     (sh_shift),
      .lines     (lines)
   );

   assign scl_oe = lines.scl_pull;
   assign sda_oe = lines.sda_pull;

endmodule

// File: rtl/i2c_byte_tx_chk.sv
module i2c_byte_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic cmd_valid,
   input logic busy,
   input logic done,
   input logic nack,
   input logic scl_oe,
   input logic sda_oe
);

   AST_ONE_LINE_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(scl_oe) |-> $stable(sda_oe)) else $error("both lines moved together"); // R2

   AST_NACK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nack) |-> done) else $error("nack rose without done"); // R4

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle"); // R8

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy) |=> busy) else $error("command not taken"); // R8

   AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> ($stable(scl_oe) && $stable(sda_oe))) else $error("lines moved between commands"); // R9

endmodule

bind i2c_byte_tx i2c_byte_tx_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .busy      (busy),
   .done      (done),
   .nack      (nack),
   .scl_oe    (scl_oe),
   .sda_oe    (sda_oe)
);

// File: tb/i2c_byte_tx_tb.sv
`timescale 1ns/1ps
module i2c_byte_tx_tb;

   localparam logic [1:0] C_NONE  = 2'b00;
   localparam logic [1:0] C_START = 2'b01;
   localparam logic [1:0] C_WRITE = 2'b10;
   localparam logic [1:0] C_STOP  = 2'b11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = 2'b00;
   logic [7:0]  cmd_data = 8'h00;
   logic [11:0] clk_div = 12'd3;
   logic        busy, done, nack, scl_oe, sda_oe;
   logic        scl_bus, sda_bus;
   logic        stretch = 1'b0;
   logic        tgt_pull = 1'b0;
   logic        ack_en = 1'b1;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   // bus monitor state
   int   starts = 0, stops = 0, done_cnt = 0;
   int   hi_cnt = 0, lo_cnt = 0, hi_last = 0, lo_last = 0;
   int   hi_min = 1000000, hi_max = 0, lo_max = 0;
   int   bitpos = 0;
   logic [7:0] rx = 8'h00;
   logic prev_scl = 1'b1, prev_sda = 1'b1;

   always #4 clk = ~clk;

   assign scl_bus = !scl_oe && !stretch;
   assign sda_bus = !sda_oe && !tgt_pull;

   i2c_byte_tx u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_data  (cmd_data),
      .clk_div   (clk_div),
      .busy      (busy),
      .done      (done),
      .nack      (nack),
      .scl_in    (scl_bus),
      .sda_in    (sda_bus),
      .scl_oe    (scl_oe),
      .sda_oe    (sda_oe)
   );

   // decodes line events and plays an acknowledging target
   always @(negedge clk) begin
      if (rst_n) begin
         if (scl_bus && prev_scl && sda_bus && !prev_sda) stops++;
         if (scl_bus && prev_scl && !sda_bus && prev_sda) begin
            starts++;
            bitpos = 0;
         end
         if (scl_bus && !prev_scl) begin
            lo_last = lo_cnt;
            if (lo_cnt > lo_max) lo_max = lo_cnt;
            lo_cnt = 0;
            if (bitpos < 8) begin
               rx = {rx[6:0], sda_bus};
               bitpos++;
            end else if (bitpos == 8) begin
               bitpos = 9;
            end
         end
         if (!scl_bus && prev_scl) begin
            hi_last = hi_cnt;
            if (hi_cnt < hi_min) hi_min = hi_cnt;
            if (hi_cnt > hi_max) hi_max = hi_cnt;
            hi_cnt = 0;
            if (bitpos == 8) tgt_pull = ack_en;
            else if (bitpos == 9) begin
               tgt_pull = 1'b0;
               bitpos = 0;
            end
         end
         if (scl_bus) hi_cnt++;
         else lo_cnt++;
         if (done) done_cnt++;
         prev_scl = scl_bus;
         prev_sda = sda_bus;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic reset_stats();
      hi_min = 1000000; hi_max = 0; lo_max = 0;
   endtask

   // issues one command, optionally pokes a STOP while busy, releases a stretch
   task automatic issue(input logic [1:0] op, input logic [7:0] d, input int poke_at,
                        input int stretch_rel, output logic nack_s, output int ndone);
      int n;
      int d0;
      while (busy) @(negedge clk);
      d0 = done_cnt;
      cmd_op = op;
      cmd_data = d;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      n = 0;
      while (!done && n < 20000) begin
         @(negedge clk);
         n++;
         if (n == stretch_rel) stretch = 1'b0;
         if (n == poke_at) begin
            cmd_valid = 1'b1;
            cmd_op = C_STOP;
         end else begin
            cmd_valid = 1'b0;
         end
      end
      cmd_valid = 1'b0;
      nack_s = nack;
      @(negedge clk);
      @(negedge clk);
      ndone = done_cnt - d0;
   endtask

   task automatic t_reset();
      chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1", "line enables after reset", {scl_oe, sda_oe}, 0);
      chk(busy == 1'b0 && done == 1'b0 && nack == 1'b0, "R1", "status after reset", {busy, done, nack}, 0);
   endtask

   task automatic t_start();
      logic nk; int nd; int s0;
      s0 = starts;
      issue(C_START, 8'h00, -1, -1, nk, nd);
      chk(starts == s0 + 1 && stops == 0, "R2", "start events", starts - s0, 1);
      chk(scl_oe == 1'b1 && sda_oe == 1'b1, "R2", "lines after START", {scl_oe, sda_oe}, 3);
      chk(nk == 1'b0 && nd == 1, "R8", "START done/nack", {nd[3:0], nk}, 2);
   endtask

   task automatic t_write_ack();
      logic nk; int nd; int s0, p0;
      s0 = starts; p0 = stops;
      ack_en = 1'b1;
      clk_div = 12'd3;
      issue(C_WRITE, 8'hA5, 5, -1, nk, nd);
      chk(rx == 8'hA5, "R3", "byte MSB first", rx, 8'hA5);
      chk(starts == s0 && stops == p0, "R3", "no stray start/stop", starts + stops, s0 + p0);
      chk(nk == 1'b0, "R4", "ack gives nack 0", nk, 0);
      chk(hi_last == 8, "R6", "SCL high phase div=3", hi_last, 8);
      chk(lo_last == 8, "R6", "SCL low phase div=3", lo_last, 8);
      chk(nd == 1, "R8", "one done per write", nd, 1);
      chk(scl_oe == 1'b1, "R8", "STOP poked while busy ignored", scl_oe, 1);
   endtask

   task automatic t_write_nack();
      logic nk; int nd;
      ack_en = 1'b0;
      issue(C_WRITE, 8'h3C, -1, -1, nk, nd);
      ack_en = 1'b1;
      chk(rx == 8'h3C, "R3", "second byte", rx, 8'h3C);
      chk(nk == 1'b1, "R4", "no ack gives nack 1", nk, 1);
      chk(nack == 1'b1, "R4", "nack held after done", nack, 1);
   endtask

   task automatic t_pause();
      int moved = 0;
      logic s0, d0;
      s0 = scl_oe; d0 = sda_oe;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (scl_oe != s0 || sda_oe != d0) moved++;
      end
      chk(moved == 0 && scl_oe == 1'b1, "R9", "SCL held low across pause", moved, 0);
   endtask

   task automatic t_fast();
      logic nk; int nd;
      clk_div = 12'd0;
      reset_stats();
      issue(C_WRITE, 8'h81, -1, -1, nk, nd);
      chk(rx == 8'h81, "R3", "byte 0x81", rx, 8'h81);
      chk(hi_min == 2 && hi_max == 2, "R6", "SCL high phase div=0", hi_max, 2);
      chk(lo_last == 2, "R6", "SCL low phase div=0", lo_last, 2);
      clk_div = 12'd3;
   endtask

   task automatic t_stretch();
      logic nk; int nd;
      clk_div = 12'd2;
      reset_stats();
      stretch = 1'b1;
      issue(C_WRITE, 8'h5A, -1, 40, nk, nd);
      chk(rx == 8'h5A, "R7", "byte under stretch", rx, 8'h5A);
      chk(hi_min == 6 && hi_max == 6, "R7", "high phase counted after release", hi_min, 6);
      chk(lo_max >= 35, "R7", "waited for SCL release", lo_max, 35);
      clk_div = 12'd3;
   endtask

   task automatic t_rstart();
      logic nk; int nd; int s0, p0;
      s0 = starts; p0 = stops;
      issue(C_START, 8'h00, -1, -1, nk, nd);
      chk(starts == s0 + 1 && stops == p0, "R2", "repeated start", starts - s0, 1);
      chk(nk == 1'b0, "R2", "repeated start nack", nk, 0);
   endtask

   task automatic t_stop();
      logic nk; int nd; int p0;
      p0 = stops;
      issue(C_STOP, 8'h00, -1, -1, nk, nd);
      chk(stops == p0 + 1, "R5", "stop event", stops - p0, 1);
      chk(scl_bus == 1'b1 && sda_bus == 1'b1, "R5", "bus free after STOP", {scl_bus, sda_bus}, 3);
      chk(nk == 1'b0, "R5", "STOP nack", nk, 0);
   endtask

   task automatic t_reject();
      logic nk; int nd; int s0, p0;
      s0 = starts; p0 = stops;
      issue(C_WRITE, 8'hFF, -1, -1, nk, nd);
      chk(nk == 1'b1 && nd == 1, "R10", "WRITE on free bus rejected", nk, 1);
      issue(C_STOP, 8'h00, -1, -1, nk, nd);
      chk(nk == 1'b1 && nd == 1, "R10", "STOP on free bus rejected", nk, 1);
      issue(C_NONE, 8'h00, -1, -1, nk, nd);
      chk(nk == 1'b0 && nd == 1, "R10", "no-op completes", nk, 0);
      chk(scl_oe == 1'b0 && sda_oe == 1'b0 && starts == s0 && stops == p0, "R10",
          "lines untouched", {scl_oe, sda_oe}, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reject();
      t_start();
      t_write_ack();
      t_write_nack();
      t_pause();
      t_fast();
      t_stretch();
      t_rstart();
      t_stop();
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R8 watchdog: actual %0d expected %0d", 150000, 0);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule